// File: doc/BRIEF.md
# Framebuffer Line-Stride Fetcher

This block streams one display frame out of a packed framebuffer in memory and into a 512-word pixel FIFO. Each frame it starts from a word-aligned base address and fetches a programmed number of 32-bit words. After every visible line it jumps the address forward by a byte skip, so a panned window inside a wider virtual framebuffer can be shown. Reads go out as bursts of up to eight granted beats on a request/grant port. Returned words are written into the FIFO in the order they arrive. A pixel unpacker drains the FIFO, and the block also hands it the bit offset of the first pixel.

Base address, line skip and first-pixel offset are staged. Software presents new values and pulses an update strobe, which captures them and raises a pending flag. The captured values become the working set only when the next frame starts, and the pending flag then clears by itself. Frame length and line length are taken directly from their inputs at every frame start. Two further flags complete the block: a busy flag, and a sticky underflow flag for a pop from an empty FIFO.

Top module: `fbf_fetch`

## Requirements
- R1: At each frame start the address counter reloads the working base with its two low bits cleared, and the first beat of the frame carries that address.
- R2: Each frame issues exactly `frame_words` granted beats. While `enable` is high at the moment the last beat is granted, a new frame starts immediately.
- R3: Beats are grouped in bursts of 8, and the last burst of a frame carries the remaining 1 to 8 words. A new burst is not requested until every word of the previous burst has returned.
- R4: A burst is started only when `fifo_level` is at or below 512 − (2·8 + 3) = 493. With no pops the FIFO therefore settles at 496 words with `mem_req` low.
- R5: Each granted beat advances a byte address by 4. When the beat is the `line_words`-th of its line, the address advances by 4 + `cfg_skip` instead. `mem_addr` is that byte address with bits [1:0] cleared. `line_words` = 0 disables the skip.
- R6: `pix_ofs` presents the 5-bit first-pixel offset of the working set.
- R7: A one-cycle `cfg_update` captures `cfg_base`, `cfg_skip` and `cfg_pix_ofs` and sets `upd_pending`. The captured set replaces the working set at the next frame start, and `upd_pending` then clears. Changes to these inputs without a new strobe have no effect on later frames.
- R8: Returned words leave the FIFO at `pix_data` in the order their beats were granted. `fifo_level` counts words held.
- R9: `pix_pop` while `fifo_level` is 0 sets the sticky `irq_underflow` and leaves the FIFO unchanged. `irq_clear` clears the flag. A new underflow and a clear in the same cycle leave the flag set.
- R10: `busy` is high while `enable` is high, and after `enable` falls it stays high until the last beat of the current frame is granted and its word has returned.
- R11: After reset `mem_req`, `busy`, `irq_underflow` and `upd_pending` are low and `fifo_level` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Run frames while high |
| cfg_base | input | 32 | Staged framebuffer base byte address |
| cfg_skip | input | 16 | Staged bytes skipped after each line |
| cfg_pix_ofs | input | 5 | Staged first-pixel bit offset |
| cfg_update | input | 1 | Strobe capturing the staged set |
| frame_words | input | 20 | Words per frame |
| line_words | input | 12 | Words per visible line, 0 = no skip |
| mem_req | output | 1 | Beat request |
| mem_addr | output | 32 | Word-aligned beat address |
| mem_gnt | input | 1 | Beat accepted this cycle |
| mem_rvalid | input | 1 | Read word valid |
| mem_rdata | input | 32 | Read word |
| pix_pop | input | 1 | Consumer takes the head word |
| pix_data | output | 32 | FIFO head word |
| pix_ofs | output | 5 | Working first-pixel bit offset |
| fifo_level | output | 10 | Words in FIFO |
| busy | output | 1 | Frame activity flag |
| upd_pending | output | 1 | Staged set awaiting frame start |
| irq_underflow | output | 1 | Sticky empty-pop flag |
| irq_clear | input | 1 | Clears the underflow flag |

## Verification
The underflow flag has two writers that can act in the same cycle: a pop on an empty FIFO sets it, and `irq_clear` clears it. The bench drives a lone empty pop, then a lone clear, then both on one edge. After the combined edge it expects the flag set, and a following lone clear brings it back to zero. A second overlap comes from the configuration path: the bench strobes an update in the middle of a running frame and then changes the base without a new strobe. The scoreboard addresses show whether the following frame took the strobed base and ignored the later change.

// File: rtl/fbf_pkg.sv
package fbf_pkg;
  localparam int unsigned ADDR_W = 32;
  localparam int unsigned SKIP_W = 16;
  localparam int unsigned POFS_W = 5;

  typedef logic [ADDR_W-1:0] addr_t;

  typedef struct packed {
    addr_t             base;
    logic [SKIP_W-1:0] skip;
    logic [POFS_W-1:0] pofs;
  } view_cfg_t;

  // Word address presented on the bus: byte address with the low two bits dropped.
  function automatic addr_t align_word(addr_t a);
    return {a[ADDR_W-1:2], 2'b00};
  endfunction

  // Byte address after one beat, with the virtual-width skip applied at a line end.
  function automatic addr_t next_byte_addr(addr_t a, logic line_end, logic [SKIP_W-1:0] skip);
    addr_t step;
    step = line_end ? (addr_t'(4) + addr_t'(skip)) : addr_t'(4);
    return a + step;
  endfunction

  // FIFO level at or below which a new burst may start.
  function automatic int unsigned fill_limit(int unsigned depth, int unsigned burst);
    return depth - (2 * burst + 3);
  endfunction
endpackage

// File: rtl/fbf_cfg_stage.sv
module fbf_cfg_stage import fbf_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  view_cfg_t         cfg_in,
  input  logic              upd_req,
  input  logic              frame_start,
  output addr_t             next_base,
  output logic [SKIP_W-1:0] work_skip,
  output logic [POFS_W-1:0] work_pofs,
  output logic              upd_pending
);
  view_cfg_t staged_q;
  view_cfg_t work_q;
  logic      pend_q;
  logic      apply;

  assign apply = frame_start && pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      staged_q <= '0;
      work_q   <= '0;
      pend_q   <= 1'b0;
    end else begin
      if (upd_req) staged_q <= cfg_in;
      if (apply)   work_q   <= staged_q;
      if (upd_req)          pend_q <= 1'b1;
      else if (frame_start) pend_q <= 1'b0;
    end
  end

  // The address generator loads its base on the same edge the working set changes.
  assign next_base   = pend_q ? staged_q.base : work_q.base;
  assign work_skip   = work_q.skip;
  assign work_pofs   = work_q.pofs;
  assign upd_pending = pend_q;

  AST_UPD_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && pend_q && !upd_req) |=> !pend_q); // R7
  AST_UPD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !frame_start) |=> pend_q); // R7
endmodule

// File: rtl/fbf_fifo.sv
module fbf_fifo #(
  parameter int unsigned DEPTH  = 512,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned LVL_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [DATA_W-1:0] wdata,
  input  logic              pop,
  input  logic              irq_clear,
  output logic [DATA_W-1:0] rdata,
  output logic [LVL_W-1:0]  level,
  output logic              irq_underflow
);
  localparam int unsigned PTR_W = $clog2(DEPTH);

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  wr_ptr;
  logic [PTR_W-1:0]  rd_ptr;
  logic [LVL_W-1:0]  lvl_q;
  logic              irq_q;
  logic              do_push;
  logic              do_pop;
  logic              uflow_evt;

  assign do_push   = push && (lvl_q != LVL_W'(DEPTH));
  assign do_pop    = pop && (lvl_q != '0);
  assign uflow_evt = pop && (lvl_q == '0);

  function automatic logic [PTR_W-1:0] wrap_inc(logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem_q[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      lvl_q  <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (do_push) wr_ptr <= wrap_inc(wr_ptr);
      if (do_pop)  rd_ptr <= wrap_inc(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   lvl_q <= lvl_q + LVL_W'(1);
        2'b01:   lvl_q <= lvl_q - LVL_W'(1);
        default: lvl_q <= lvl_q;
      endcase
      if (uflow_evt)      irq_q <= 1'b1;
      else if (irq_clear) irq_q <= 1'b0;
    end
  end

  assign rdata         = mem_q[rd_ptr];
  assign level         = lvl_q;
  assign irq_underflow = irq_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (lvl_q < LVL_W'(DEPTH))); // R8
  AST_UFLOW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    uflow_evt |=> irq_q); // R9
  AST_UFLOW_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (uflow_evt && !push) |=> (lvl_q == '0)); // R9
endmodule

// File: rtl/fbf_fetch_ctl.sv
module fbf_fetch_ctl import fbf_pkg::*; #(
  parameter int unsigned BURST_LEN = 8,
  parameter int unsigned FRAME_W   = 20,
  parameter int unsigned LINE_W    = 12,
  parameter int unsigned LVL_W     = 10,
  parameter int unsigned LIMIT     = 493
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [FRAME_W-1:0] frame_words,
  input  logic [LINE_W-1:0] line_words,
  input  addr_t             next_base,
  input  logic [SKIP_W-1:0] work_skip,
  input  logic [LVL_W-1:0]  fifo_level,
  input  logic              mem_gnt,
  input  logic              mem_rvalid,
  output logic              mem_req,
  output addr_t             mem_addr,
  output logic              frame_start,
  output logic              busy
);
  localparam int unsigned BEAT_W = $clog2(BURST_LEN + 1);

  addr_t              addr_q;
  logic [FRAME_W-1:0] words_q;
  logic [BEAT_W-1:0]  beats_q;
  logic [BEAT_W-1:0]  outst_q;
  logic [LINE_W-1:0]  line_q;

  logic              burst_start;
  logic              beat_take;
  logic              line_end;
  logic [BEAT_W-1:0] burst_len;

  assign frame_start = enable && (words_q == '0) && (beats_q == '0);
  assign burst_start = (words_q != '0) && (beats_q == '0) && (outst_q == '0)
                       && (fifo_level <= LVL_W'(LIMIT));
  assign beat_take   = (beats_q != '0) && mem_gnt;
  assign line_end    = (line_words != '0) && ((line_q + LINE_W'(1)) == line_words);
  assign burst_len   = (words_q >= FRAME_W'(BURST_LEN)) ? BEAT_W'(BURST_LEN) : BEAT_W'(words_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q  <= '0;
      words_q <= '0;
      beats_q <= '0;
      outst_q <= '0;
      line_q  <= '0;
    end else begin
      if (frame_start) begin
        addr_q  <= align_word(next_base);
        words_q <= frame_words;
        line_q  <= '0;
      end else if (beat_take) begin
        addr_q  <= next_byte_addr(addr_q, line_end, work_skip);
        words_q <= words_q - FRAME_W'(1);
        line_q  <= line_end ? '0 : line_q + LINE_W'(1);
      end
      if (burst_start)    beats_q <= burst_len;
      else if (beat_take) beats_q <= beats_q - BEAT_W'(1);
      case ({beat_take, mem_rvalid})
        2'b10:   outst_q <= outst_q + BEAT_W'(1);
        2'b01:   outst_q <= outst_q - BEAT_W'(1);
        default: outst_q <= outst_q;
      endcase
    end
  end

  assign mem_req  = beats_q != '0;
  assign mem_addr = align_word(addr_q);
  assign busy     = enable || (words_q != '0) || (beats_q != '0) || (outst_q != '0);

  AST_BURST_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req) |-> ($past(fifo_level) <= LVL_W'(LIMIT))); // R4
  AST_RVALID_OWED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rvalid |-> (outst_q != '0)); // R3
  AST_WORD_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    beat_take |=> (words_q == $past(words_q) - FRAME_W'(1))); // R2
  AST_BURST_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    burst_start |=> (beats_q <= BEAT_W'(BURST_LEN))); // R3
endmodule

// File: rtl/fbf_fetch.sv
module fbf_fetch import fbf_pkg::*; #(
  parameter int unsigned FIFO_DEPTH = 512,
  parameter int unsigned BURST_LEN  = 8,
  parameter int unsigned FRAME_W    = 20,
  parameter int unsigned LINE_W     = 12,
  parameter int unsigned DATA_W     = 32,
  localparam int unsigned LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic [ADDR_W-1:0]  cfg_base,
  input  logic [SKIP_W-1:0]  cfg_skip,
  input  logic [POFS_W-1:0]  cfg_pix_ofs,
  input  logic               cfg_update,
  input  logic [FRAME_W-1:0] frame_words,
  input  logic [LINE_W-1:0]  line_words,
  output logic               mem_req,
  output logic [ADDR_W-1:0]  mem_addr,
  input  logic               mem_gnt,
  input  logic               mem_rvalid,
  input  logic [DATA_W-1:0]  mem_rdata,
  input  logic               pix_pop,
  output logic [DATA_W-1:0]  pix_data,
  output logic [POFS_W-1:0]  pix_ofs,
  output logic [LVL_W-1:0]   fifo_level,
  output logic               busy,
  output logic               upd_pending,
  output logic               irq_underflow,
  input  logic               irq_clear
);
  localparam int unsigned LIMIT = fill_limit(FIFO_DEPTH, BURST_LEN);

  view_cfg_t         cfg_in;
  addr_t             next_base;
  logic [SKIP_W-1:0] work_skip;
  logic              frame_start;

  assign cfg_in = '{base: cfg_base, skip: cfg_skip, pofs: cfg_pix_ofs};

  fbf_cfg_stage u_stage (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_in      (cfg_in),
    .upd_req     (cfg_update),
    .frame_start (frame_start),
    .next_base   (next_base),
    .work_skip   (work_skip),
    .work_pofs   (pix_ofs),
    .upd_pending (upd_pending)
  );

  fbf_fetch_ctl #(
    .BURST_LEN (BURST_LEN),
    .FRAME_W   (FRAME_W),
    .LINE_W    (LINE_W),
    .LVL_W     (LVL_W),
    .LIMIT     (LIMIT)
  ) u_ctl (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (enable),
    .frame_words (frame_words),
    .line_words  (line_words),
    .next_base   (next_base),
    .work_skip   (work_skip),
    .fifo_level  (fifo_level),
    .mem_gnt     (mem_gnt),
    .mem_rvalid  (mem_rvalid),
    .mem_req     (mem_req),
    .mem_addr    (mem_addr),
    .frame_start (frame_start),
    .busy        (busy)
  );

  fbf_fifo #(
    .DEPTH  (FIFO_DEPTH),
    .DATA_W (DATA_W),
    .LVL_W  (LVL_W)
  ) u_fifo (
    .clk           (clk),
    .rst_n         (rst_n),
    .push          (mem_rvalid),
    .wdata         (mem_rdata),
    .pop           (pix_pop),
    .irq_clear     (irq_clear),
    .rdata         (pix_data),
    .level         (fifo_level),
    .irq_underflow (irq_underflow)
  );

  AST_START_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (mem_addr[1:0] == 2'b00) && (mem_addr[ADDR_W-1:2] == $past(next_base[ADDR_W-1:2]))); // R1
  AST_BUSY_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !enable && mem_req) |=> busy); // R10
endmodule

// File: tb/sim_fbf_fetch.sv
module sim_fbf_fetch;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic [31:0] cfg_base = '0;
  logic [15:0] cfg_skip = '0;
  logic [4:0]  cfg_pix_ofs = '0;
  logic        cfg_update = 1'b0;
  logic [19:0] frame_words = '0;
  logic [11:0] line_words = '0;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_gnt = 1'b1;
  logic        mem_rvalid;
  logic [31:0] mem_rdata;
  logic        pix_pop;
  logic [31:0] pix_data;
  logic [4:0]  pix_ofs;
  logic [9:0]  fifo_level;
  logic        busy;
  logic        upd_pending;
  logic        irq_underflow;
  logic        irq_clear = 1'b0;

  always #10 clk = ~clk;

  fbf_fetch u0 (
    .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_base(cfg_base), .cfg_skip(cfg_skip),
    .cfg_pix_ofs(cfg_pix_ofs), .cfg_update(cfg_update), .frame_words(frame_words),
    .line_words(line_words), .mem_req(mem_req), .mem_addr(mem_addr), .mem_gnt(mem_gnt),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .pix_pop(pix_pop), .pix_data(pix_data),
    .pix_ofs(pix_ofs), .fifo_level(fifo_level), .busy(busy), .upd_pending(upd_pending),
    .irq_underflow(irq_underflow), .irq_clear(irq_clear)
  );

  int checks = 0;
  int failures = 0;

  function automatic logic [31:0] word_of(logic [31:0] a);
    return {~a[15:0], a[15:0]} ^ 32'h5A5A_0000;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Ideal memory: two-cycle read latency, one word per granted beat.
  logic        p1_v = 1'b0, p2_v = 1'b0;
  logic [31:0] p1_a = '0, p2_a = '0;
  always @(posedge clk) begin
    p1_v <= rst_n && mem_req && mem_gnt;
    p1_a <= mem_addr;
    p2_v <= rst_n && p1_v;
    p2_a <= p1_a;
  end
  assign mem_rvalid = p2_v;
  assign mem_rdata  = word_of(p2_a);

  // Scoreboard queues filled by the driver task and the grant monitor.
  logic [31:0] exp_addr [$];
  int          exp_len  [$];
  logic [31:0] exp_data [$];

  task automatic expect_frame(input logic [31:0] base, input int fw, input int lw, input int skip);
    longint unsigned b = longint'(base) & ~64'h3;
    int col = 0;
    for (int i = 0; i < fw; i++) begin
      exp_addr.push_back(32'(b & ~64'h3));
      col++;
      if (lw != 0 && col == lw) begin b = b + 4 + longint'(skip); col = 0; end
      else b = b + 4;
    end
    for (int left = fw; left > 0; left -= 8) exp_len.push_back(left > 8 ? 8 : left);
  endtask

  bit          stall_mode = 1'b0;
  bit          cons_en = 1'b0;
  logic        cons_pop = 1'b0;
  logic        uf_pop = 1'b0;
  logic        req_prev = 1'b0;
  int          beat_cnt = 0;
  int          cyc = 0;
  logic [31:0] a_exp;
  int          l_exp;
  assign pix_pop = cons_pop | uf_pop;

  always @(negedge clk) begin
    cyc++;
    mem_gnt = stall_mode ? ((cyc % 3) != 1) : 1'b1;
    if (rst_n) begin
      if (mem_req && !req_prev)
        chk(fifo_level <= 10'd493, "R4 burst start level", 32'(fifo_level), 32'd493);
      if (mem_req && mem_gnt) begin
        beat_cnt++;
        if (exp_addr.size() == 0) chk(1'b0, "R2 unexpected beat", mem_addr, 32'h0);
        else begin
          a_exp = exp_addr.pop_front();
          chk(mem_addr == a_exp, "R1/R5 beat address", mem_addr, a_exp);
          exp_data.push_back(word_of(a_exp));
        end
      end
      if (!mem_req && req_prev) begin
        if (exp_len.size() == 0) chk(1'b0, "R3 unexpected burst", 32'(beat_cnt), 32'h0);
        else begin
          l_exp = exp_len.pop_front();
          chk(beat_cnt == l_exp, "R3 burst length", 32'(beat_cnt), 32'(l_exp));
        end
        beat_cnt = 0;
      end
      req_prev = mem_req;
      cons_pop = cons_en && (fifo_level != '0);
      if (cons_pop) begin
        if (exp_data.size() == 0) chk(1'b0, "R8 unexpected word", pix_data, 32'h0);
        else begin
          a_exp = exp_data.pop_front();
          chk(pix_data == a_exp, "R8 fifo word", pix_data, a_exp);
        end
      end
    end else begin
      cons_pop = 1'b0;
      req_prev = 1'b0;
    end
  end

  task automatic stage(input logic [31:0] b, input int sk, input int po);
    cfg_base = b; cfg_skip = 16'(sk); cfg_pix_ofs = 5'(po);
    cfg_update = 1'b1;
    @(negedge clk);
    cfg_update = 1'b0;
  endtask

  task automatic wait_drained();
    while (busy || fifo_level != '0) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(exp_addr.size() == 0 && exp_data.size() == 0 && exp_len.size() == 0,
        "R2 frame complete", 32'(exp_addr.size() + exp_data.size()), 32'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++; checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(!mem_req && !busy && !irq_underflow && !upd_pending && fifo_level == '0,
        "R11 reset state", {mem_req, busy, irq_underflow, upd_pending, 18'h0, fifo_level}, 32'h0);

    // R1/R6/R10: single frame from an unaligned base, enable dropped after start
    cons_en = 1'b1;
    frame_words = 20'd20; line_words = 12'd0;
    stage(32'h0000_1003, 0, 5);
    chk(upd_pending, "R7 pending after strobe", 32'(upd_pending), 32'h1);
    expect_frame(32'h0000_1003, 20, 0, 0);
    enable = 1'b1;
    @(negedge clk);
    enable = 1'b0;
    chk(busy, "R10 busy after enable removed", 32'(busy), 32'h1);
    chk(pix_ofs == 5'd5, "R6 working offset", 32'(pix_ofs), 32'd5);
    chk(!upd_pending, "R7 pending self-clears", 32'(upd_pending), 32'h0);
    wait_drained();
    chk(!busy, "R10 busy low after frame", 32'(busy), 32'h0);

    // R5: line skip with a non-word skip and grant stalls
    stall_mode = 1'b1;
    frame_words = 20'd9; line_words = 12'd3;
    stage(32'h0000_2000, 10, 9);
    expect_frame(32'h0000_2000, 9, 3, 10);
    enable = 1'b1;
    @(negedge clk);
    enable = 1'b0;
    wait_drained();
    stall_mode = 1'b0;

    // R7: strobe mid-frame, later change without strobe, back-to-back frames (R2)
    frame_words = 20'd24; line_words = 12'd4;
    stage(32'h0000_4000, 8, 3);
    expect_frame(32'h0000_4000, 24, 4, 8);
    expect_frame(32'h0000_8004, 24, 4, 8);
    enable = 1'b1;
    repeat (4) @(negedge clk);
    chk(pix_ofs == 5'd3, "R6 frame one offset", 32'(pix_ofs), 32'd3);
    stage(32'h0000_8004, 8, 17);
    chk(upd_pending, "R7 pending held mid-frame", 32'(upd_pending), 32'h1);
    chk(pix_ofs == 5'd3, "R7 offset unchanged before frame start", 32'(pix_ofs), 32'd3);
    cfg_base = 32'h0000_C000; cfg_pix_ofs = 5'd30;
    while (upd_pending) @(negedge clk);
    enable = 1'b0;
    chk(pix_ofs == 5'd17, "R7 offset applied at frame start", 32'(pix_ofs), 32'd17);
    wait_drained();

    // R4: fill without consumer
    cons_en = 1'b0;
    frame_words = 20'd600; line_words = 12'd0;
    stage(32'h0001_0000, 0, 0);
    expect_frame(32'h0001_0000, 600, 0, 0);
    enable = 1'b1;
    @(negedge clk);
    enable = 1'b0;
    repeat (1500) @(negedge clk);
    chk(fifo_level == 10'd496, "R4 fill settles", 32'(fifo_level), 32'd496);
    chk(!mem_req && busy, "R4 request held off", {30'h0, mem_req, busy}, 32'h1);
    cons_en = 1'b1;
    wait_drained();
    cons_en = 1'b0;
    @(negedge clk);

    // R9: underflow set, clear, and both on one edge
    uf_pop = 1'b1;
    @(negedge clk);
    uf_pop = 1'b0;
    chk(irq_underflow, "R9 empty pop sets flag", 32'(irq_underflow), 32'h1);
    chk(fifo_level == '0, "R9 fifo unchanged", 32'(fifo_level), 32'h0);
    irq_clear = 1'b1;
    @(negedge clk);
    irq_clear = 1'b0;
    chk(!irq_underflow, "R9 clear", 32'(irq_underflow), 32'h0);
    uf_pop = 1'b1; irq_clear = 1'b1;
    @(negedge clk);
    uf_pop = 1'b0; irq_clear = 1'b0;
    chk(irq_underflow, "R9 set wins over clear", 32'(irq_underflow), 32'h1);
    irq_clear = 1'b1;
    @(negedge clk);
    irq_clear = 1'b0;
    chk(!irq_underflow, "R9 clear after overlap", 32'(irq_underflow), 32'h0);
    repeat (4) @(negedge clk);
    chk(!mem_req && !busy, "R10 idle at end", {30'h0, mem_req, busy}, 32'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule